// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block takes an incoming Ethernet frame and writes it into one page of packet memory in a fixed receive image. A frame begins with a descriptor that carries its length in bytes. The payload bytes then follow one per accepted beat. For each frame the block first decides whether to keep it. If it keeps it, it asks an external page allocator for a page. It then writes the image into that page through a byte-wide memory write port. The image has four parts in this order: a 4-byte header, the payload padded to the minimum frame size, an optional 4-byte frame check sequence, and a 2-byte trailer.

Once the trailer is written, the block pushes the page number onto the receive queue and pulses the receive interrupt set line for one cycle. A frame that is dropped is still drained from the byte stream, so the stream stays aligned for the next frame. The stream is held off while the header, the padding, the check sequence and the trailer are being written.

Top module: `rx_frame_formatter`

## Requirements
- R1: When receive is disabled (`cfg_rx_en` low) or soft reset is asserted (`cfg_soft_rst` high) at the time the descriptor is accepted, the frame's bytes are consumed and discarded. The frame causes no memory write, no allocation request and no queue push.
- R2: The byte count is C = max(64, L with bit 0 cleared) + 6, plus 4 more when `cfg_strip_crc` is low, where L is the frame length. A frame whose C exceeds 2048 is consumed and discarded with no write and no push.
- R3: When the allocator answers a request with `alloc_gnt` high and `alloc_ok` low, the frame is consumed and discarded with no write and no push.
- R4: Image bytes 2 and 3 hold C, low byte first. The number of bytes written for a kept frame equals C, and they cover addresses 0 to C-1 of the granted page.
- R5: Image byte 0 is 0x00. In image byte 1, bit 3 is set when L > 1518, bit 4 is set when L is odd, and all other bits are 0.
- R6: For L >= 64, the payload starts at address 4 and holds the first L rounded down to even bytes. For L < 64, all L bytes (including an odd last byte) are written from address 4, followed by zero bytes up to 64 payload bytes.
- R7: With `cfg_strip_crc` low, a CRC-32 follows the payload region, least significant byte first. It uses the reflected polynomial 0xEDB88320, an all-ones preset and final inversion, and covers the frame as stored: all L bytes for L >= 64, or the 64 padded bytes for L < 64. With `cfg_strip_crc` high, no CRC bytes are written.
- R8: The last two image bytes are the odd last frame byte followed by 0x60 when L is odd and L >= 64. Otherwise they are 0x00 followed by 0x40.
- R9: After the last image byte is written, `rxq_push` pulses for exactly one cycle with `rxq_page` equal to the granted page, and `rx_irq_set` pulses in the same cycle.
- R10: `s_ready` is low while the header, padding, CRC and trailer are written and while an allocation is pending. `alloc_req` stays high from its rise until `alloc_gnt` is seen.
- R11: After reset, `hdr_ready` is high and `s_ready`, `alloc_req`, `mem_we`, `rxq_push` and `rx_irq_set` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_soft_rst | input | 1 | Soft reset in force; frames are dropped |
| cfg_strip_crc | input | 1 | High: no CRC is stored |
| hdr_valid | input | 1 | Frame descriptor valid |
| hdr_len | input | LEN_W | Frame length in bytes |
| hdr_ready | output | 1 | Descriptor accepted when high with hdr_valid |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Payload byte accepted when high with s_valid |
| alloc_req | output | 1 | Page allocation request |
| alloc_gnt | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Answer carries a page (low: no page free) |
| alloc_page | input | PAGE_W | Granted page number |
| mem_we | output | 1 | Memory byte write strobe |
| mem_page | output | PAGE_W | Page written |
| mem_addr | output | ADDR_W | Byte address within the page |
| mem_wdata | output | 8 | Byte written |
| rxq_push | output | 1 | Push the finished page onto the receive queue |
| rxq_page | output | PAGE_W | Page pushed |
| rx_irq_set | output | 1 | One-cycle request to set the receive interrupt |

## Verification
The bench aims at the length boundaries where the image changes shape. It drives 40 and 41 bytes (padding, with the odd byte inside the pad region), 100 and 101 bytes (an odd byte moved into the trailer), 1520 bytes (too-long flag) and 2039 bytes (exactly 2048 bytes stored). It also sends a 2040-byte frame with the CRC kept, whose count of 2050 must be refused. A design that put the odd byte before the CRC, or counted it in the payload, would shift the CRC and trailer regions and fail the byte-wise compare. A design that padded from the even-rounded length would lose the odd byte of a short frame. All three drop causes are checked for stray writes and pushes, and a stream that is not drained would hang the frame that follows.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MIN_FRAME  = 64;
    localparam int LONG_LIMIT = 1518;
    localparam int HDR_BYTES  = 4;
    localparam int FCS_BYTES  = 4;
    localparam int TRL_BYTES  = 2;

    localparam logic [7:0] CTRL_ODD  = 8'h60;
    localparam logic [7:0] CTRL_EVEN = 8'h40;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ALLOC,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_FCS,
        ST_TRL,
        ST_DONE,
        ST_DISC
    } rxf_state_e;

    typedef struct packed {
        logic [15:0] count;
        logic [7:0]  stat_hi;
        logic        odd;
        logic        short_f;
        logic        too_big;
    } rxf_info_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_len_calc.sv
module rxf_len_calc
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output rxf_info_t        info
);

    logic [15:0] len16;
    logic [15:0] base;

    always_comb begin
        len16        = 16'(len);
        info.short_f = len16 < 16'(MIN_FRAME);
        base         = info.short_f ? 16'(MIN_FRAME) : {len16[15:1], 1'b0};
        info.count   = base + 16'(HDR_BYTES + TRL_BYTES) + (strip ? 16'd0 : 16'(FCS_BYTES));
        info.odd     = len16[0];
        info.stat_hi = {3'b000, len16[0], (len16 > 16'(LONG_LIMIT)), 3'b000};
        info.too_big = info.count > 16'(PAGE_BYTES);
    end

endmodule

// File: rtl/rxf_crc.sv
module rxf_crc
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, data);
        end
    end

    assign fcs = ~crc_q;

    a_r7_init_preset: assert property (@(posedge clk) disable iff (rst)
        init |=> (fcs == 32'd0));

endmodule

// File: rtl/rxf_seq.sv
module rxf_seq
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_W     = 2,
    parameter int ADDR_W     = 11,
    localparam int WP_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_soft_rst,
    input  logic              cfg_strip_crc,
    input  logic              hdr_valid,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_ready,
    input  rxf_info_t         info,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    output logic              s_ready,
    output logic              alloc_req,
    input  logic              alloc_gnt,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              crc_init,
    output logic              crc_en,
    output logic [7:0]        crc_data,
    input  logic [31:0]       fcs,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rx_irq_set
);

    rxf_state_e        state_q;
    rxf_info_t         info_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [WP_W-1:0]   wptr_q;
    logic [1:0]        sub_q;
    logic [7:0]        odd_byte_q;
    logic [PAGE_W-1:0] page_q;
    logic              keep_fcs_q;

    logic hdr_take, drop_now, last_byte, odd_long, store_byte;

    assign hdr_take   = (state_q == ST_IDLE) && hdr_valid;
    assign drop_now   = !cfg_rx_en || cfg_soft_rst || info.too_big;
    assign last_byte  = (cnt_q == len_q - LEN_W'(1));
    assign odd_long   = info_q.odd && !info_q.short_f;
    assign store_byte = !(last_byte && odd_long);
    assign crc_init   = hdr_take;
    assign mem_page   = page_q;
    assign mem_addr   = wptr_q[ADDR_W-1:0];
    assign rxq_page   = page_q;

    always_comb begin
        hdr_ready  = 1'b0;
        s_ready    = 1'b0;
        alloc_req  = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = 8'd0;
        crc_en     = 1'b0;
        crc_data   = 8'd0;
        rxq_push   = 1'b0;
        rx_irq_set = 1'b0;
        unique case (state_q)
            ST_IDLE:  hdr_ready = 1'b1;
            ST_ALLOC: alloc_req = 1'b1;
            ST_HDR: begin
                mem_we = 1'b1;
                unique case (sub_q)
                    2'd0: mem_wdata = 8'd0;
                    2'd1: mem_wdata = info_q.stat_hi;
                    2'd2: mem_wdata = info_q.count[7:0];
                    default: mem_wdata = info_q.count[15:8];
                endcase
            end
            ST_PAY: begin
                s_ready   = 1'b1;
                mem_we    = s_valid && store_byte;
                mem_wdata = s_data;
                crc_en    = s_valid;
                crc_data  = s_data;
            end
            ST_PAD: begin
                mem_we = 1'b1;
                crc_en = 1'b1;
            end
            ST_FCS: begin
                mem_we = 1'b1;
                unique case (sub_q)
                    2'd0: mem_wdata = fcs[7:0];
                    2'd1: mem_wdata = fcs[15:8];
                    2'd2: mem_wdata = fcs[23:16];
                    default: mem_wdata = fcs[31:24];
                endcase
            end
            ST_TRL: begin
                mem_we = 1'b1;
                if (sub_q == 2'd0) mem_wdata = odd_long ? odd_byte_q : 8'd0;
                else               mem_wdata = odd_long ? CTRL_ODD : CTRL_EVEN;
            end
            ST_DONE: begin
                rxq_push   = 1'b1;
                rx_irq_set = 1'b1;
            end
            ST_DISC:  s_ready = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            info_q     <= '0;
            len_q      <= '0;
            cnt_q      <= '0;
            wptr_q     <= '0;
            sub_q      <= '0;
            odd_byte_q <= '0;
            page_q     <= '0;
            keep_fcs_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (hdr_valid) begin
                    len_q      <= hdr_len;
                    info_q     <= info;
                    keep_fcs_q <= !cfg_strip_crc;
                    cnt_q      <= '0;
                    wptr_q     <= '0;
                    sub_q      <= '0;
                    if (!drop_now)          state_q <= ST_ALLOC;
                    else if (hdr_len != '0) state_q <= ST_DISC;
                end
                ST_ALLOC: if (alloc_gnt) begin
                    if (alloc_ok) begin
                        page_q  <= alloc_page;
                        state_q <= ST_HDR;
                    end else begin
                        state_q <= (len_q == '0) ? ST_IDLE : ST_DISC;
                    end
                end
                ST_HDR: begin
                    wptr_q <= wptr_q + WP_W'(1);
                    sub_q  <= sub_q + 2'd1;
                    if (sub_q == 2'd3) begin
                        sub_q   <= '0;
                        state_q <= (len_q == '0) ? ST_PAD : ST_PAY;
                    end
                end
                ST_PAY: if (s_valid) begin
                    cnt_q <= cnt_q + LEN_W'(1);
                    if (store_byte) wptr_q <= wptr_q + WP_W'(1);
                    else            odd_byte_q <= s_data;
                    if (last_byte) begin
                        if (info_q.short_f)  state_q <= ST_PAD;
                        else if (keep_fcs_q) state_q <= ST_FCS;
                        else                 state_q <= ST_TRL;
                    end
                end
                ST_PAD: begin
                    wptr_q <= wptr_q + WP_W'(1);
                    if (wptr_q == WP_W'(HDR_BYTES + MIN_FRAME - 1))
                        state_q <= keep_fcs_q ? ST_FCS : ST_TRL;
                end
                ST_FCS: begin
                    wptr_q <= wptr_q + WP_W'(1);
                    sub_q  <= sub_q + 2'd1;
                    if (sub_q == 2'd3) state_q <= ST_TRL;
                end
                ST_TRL: begin
                    wptr_q <= wptr_q + WP_W'(1);
                    sub_q  <= sub_q + 2'd1;
                    if (sub_q == 2'd1) begin
                        sub_q   <= '0;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                ST_DISC: if (s_valid) begin
                    cnt_q <= cnt_q + LEN_W'(1);
                    if (last_byte) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r9_push_single: assert property (@(posedge clk) disable iff (rst)
        rxq_push |=> !rxq_push);

    a_r4_image_size: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> (16'(wptr_q) == info_q.count));

    a_r2_no_oversize_push: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> !info_q.too_big);

    a_r3_no_write_after_fail: assert property (@(posedge clk) disable iff (rst)
        (alloc_gnt && !alloc_ok && alloc_req) |=> !mem_we);

    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_gnt) |=> alloc_req);

    a_r6_write_in_image: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (16'(wptr_q) < info_q.count));

endmodule

// File: rtl/rx_frame_formatter.sv
module rx_frame_formatter
    import rxf_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    parameter int LEN_W      = 12,
    localparam int PAGE_W    = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_soft_rst,
    input  logic              cfg_strip_crc,
    input  logic              hdr_valid,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_ready,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    output logic              s_ready,
    output logic              alloc_req,
    input  logic              alloc_gnt,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rx_irq_set
);

    rxf_info_t   info;
    logic        crc_init, crc_en;
    logic [7:0]  crc_data;
    logic [31:0] fcs;

    rxf_len_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_calc (
        .len   (hdr_len),
        .strip (cfg_strip_crc),
        .info  (info)
    );

    rxf_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .en   (crc_en),
        .data (crc_data),
        .fcs  (fcs)
    );

    rxf_seq #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .cfg_rx_en     (cfg_rx_en),
        .cfg_soft_rst  (cfg_soft_rst),
        .cfg_strip_crc (cfg_strip_crc),
        .hdr_valid     (hdr_valid),
        .hdr_len       (hdr_len),
        .hdr_ready     (hdr_ready),
        .info          (info),
        .s_valid       (s_valid),
        .s_data        (s_data),
        .s_ready       (s_ready),
        .alloc_req     (alloc_req),
        .alloc_gnt     (alloc_gnt),
        .alloc_ok      (alloc_ok),
        .alloc_page    (alloc_page),
        .crc_init      (crc_init),
        .crc_en        (crc_en),
        .crc_data      (crc_data),
        .fcs           (fcs),
        .mem_we        (mem_we),
        .mem_page      (mem_page),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .rxq_push      (rxq_push),
        .rxq_page      (rxq_page),
        .rx_irq_set    (rx_irq_set)
    );

endmodule

// File: tb/rx_frame_formatter_tb_top.sv
`timescale 1ns/1ps
module rx_frame_formatter_tb_top;

    localparam int PAGES  = 4;
    localparam int PBYTES = 2048;
    localparam int LEN_W  = 12;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_rx_en = 1'b1, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
    logic hdr_valid = 1'b0;
    logic [LEN_W-1:0] hdr_len = '0;
    logic hdr_ready;
    logic s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic s_ready;
    logic alloc_req;
    logic alloc_gnt = 1'b0, alloc_ok = 1'b0;
    logic [PAGE_W-1:0] alloc_page = '0;
    logic mem_we;
    logic [PAGE_W-1:0] mem_page;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic rxq_push;
    logic [PAGE_W-1:0] rxq_page;
    logic rx_irq_set;

    always #5 clk = ~clk;

    rx_frame_formatter #(.PAGES(PAGES), .PAGE_BYTES(PBYTES), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
        .cfg_strip_crc(cfg_strip_crc), .hdr_valid(hdr_valid), .hdr_len(hdr_len),
        .hdr_ready(hdr_ready), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_ok(alloc_ok),
        .alloc_page(alloc_page), .mem_we(mem_we), .mem_page(mem_page),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rxq_push(rxq_push),
        .rxq_page(rxq_page), .rx_irq_set(rx_irq_set)
    );

    int nchecks = 0;
    int nerrors = 0;
    int npush = 0;
    int nwr = 0;
    int ready_viol = 0;
    int req_viol = 0;
    int cur_count = 0;
    bit tb_ok = 1'b1;
    logic [PAGE_W-1:0] tb_page = '0;
    int wait_c = 0;
    bit req_prev = 1'b0, gnt_prev = 1'b0;
    bit done = 1'b0;

    logic [7:0] mem [PAGES][PBYTES];
    logic [7:0] fb [4096];
    logic [7:0] img [PBYTES];
    int exp_q[$];

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // memory model and allocator model
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_page][mem_addr] <= mem_wdata;
            nwr <= nwr + 1;
        end
        if (rst) begin
            alloc_gnt <= 1'b0;
            wait_c <= 0;
        end else if (alloc_req && !alloc_gnt) begin
            if (wait_c == 2) begin
                alloc_gnt  <= 1'b1;
                alloc_ok   <= tb_ok;
                alloc_page <= tb_page;
                wait_c     <= 0;
            end else begin
                wait_c <= wait_c + 1;
            end
        end else begin
            alloc_gnt <= 1'b0;
        end
    end

    // monitor: scoreboard of queued pages, handshake rules (R9, R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (rxq_push) begin
                npush++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected queue push", int'(rxq_page), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(rxq_page) == e, "R9", "queued page", int'(rxq_page), e);
                    check(rx_irq_set, "R9", "irq set with push", int'(rx_irq_set), 1);
                end
            end
            if (mem_we && s_ready && (int'(mem_addr) < 4 || int'(mem_addr) >= cur_count - 2))
                ready_viol++;
            if (alloc_req && s_ready) ready_viol++;
            if (req_prev && !gnt_prev && !alloc_req) req_viol++;
            req_prev = alloc_req;
            gnt_prev = alloc_gnt;
        end
    end

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) fb[i] = 8'((i * 13 + seed * 7 + (i >> 3)) & 255);
        hdr_valid = 1'b1;
        hdr_len = LEN_W'(len);
        while (!hdr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data = fb[i];
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
    endtask

    function automatic int calc_count(input int len, input bit strip);
        int b;
        b = (len < 64) ? 64 : (len & ~1);
        return b + 6 + (strip ? 0 : 4);
    endfunction

    task automatic compare_region(input int pg, input int lo, input int hi, input string req, input string what);
        int bad = 0, fa = 0, fe = 0;
        for (int a = lo; a < hi; a++) begin
            if (mem[pg][a] !== img[a]) begin
                if (bad == 0) begin
                    fa = int'(mem[pg][a]);
                    fe = int'(img[a]);
                end
                bad++;
            end
        end
        check(bad == 0, req, what, fa, fe);
    endtask

    task automatic run_frame(input int len, input bit strip, input int pg, input int seed);
        int cnt, ep, n, p0, w0, pos;
        logic [31:0] c;
        cfg_rx_en = 1'b1;
        cfg_soft_rst = 1'b0;
        cfg_strip_crc = strip;
        tb_ok = 1'b1;
        tb_page = PAGE_W'(pg);
        cnt = calc_count(len, strip);
        cur_count = cnt;
        for (int a = 0; a < PBYTES; a++) mem[pg][a] = 8'hxx;
        exp_q.push_back(pg);
        p0 = npush;
        w0 = nwr;
        send_frame(len, seed);
        for (int t = 0; t < 100 && npush == p0; t++) @(negedge clk);
        check(npush == p0 + 1, "R9", "push after frame", npush - p0, 1);
        // expected image, from the requirements
        ep = (len < 64) ? 64 : (len & ~1);
        img[0] = 8'd0;
        img[1] = 8'(((len > 1518) ? 8 : 0) | ((len % 2 == 1) ? 16 : 0));
        img[2] = 8'(cnt & 255);
        img[3] = 8'(cnt >> 8);
        for (int i = 0; i < ep; i++) img[4 + i] = (i < len) ? fb[i] : 8'd0;
        pos = 4 + ep;
        if (!strip) begin
            n = (len < 64) ? 64 : len;
            c = 32'hFFFF_FFFF;
            for (int i = 0; i < n; i++) begin
                c = c ^ {24'd0, (i < len) ? fb[i] : 8'd0};
                for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
            c = ~c;
            for (int k = 0; k < 4; k++) img[pos + k] = c[8*k +: 8];
            pos = pos + 4;
        end
        if ((len % 2 == 1) && len >= 64) begin
            img[pos] = fb[len - 1];
            img[pos + 1] = 8'h60;
        end else begin
            img[pos] = 8'h00;
            img[pos + 1] = 8'h40;
        end
        check(nwr - w0 == cnt, "R4", "bytes written equals count", nwr - w0, cnt);
        compare_region(pg, 2, 4, "R4", "count field");
        compare_region(pg, 0, 2, "R5", "status word");
        compare_region(pg, 4, 4 + ep, "R6", "payload and padding");
        if (!strip) compare_region(pg, 4 + ep, 8 + ep, "R7", "crc bytes");
        compare_region(pg, pos, pos + 2, "R8", "trailer word");
        check(pos + 2 == cnt, "R7", "trailer position vs count", pos + 2, cnt);
    endtask

    task automatic run_drop(input int len, input bit strip, input bit en, input bit srst,
                            input bit aok, input string req);
        int p0, w0;
        cfg_rx_en = en;
        cfg_soft_rst = srst;
        cfg_strip_crc = strip;
        tb_ok = aok;
        tb_page = 2'd3;
        p0 = npush;
        w0 = nwr;
        send_frame(len, 5);
        repeat (12) @(negedge clk);
        check(nwr == w0, req, "no write on drop", nwr - w0, 0);
        check(npush == p0, req, "no push on drop", npush - p0, 0);
        check(hdr_ready, req, "ready for next frame", int'(hdr_ready), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        nchecks++;
        nerrors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(hdr_ready, "R11", "hdr_ready after reset", int'(hdr_ready), 1);
        check(!s_ready, "R11", "s_ready after reset", int'(s_ready), 0);
        check(!alloc_req, "R11", "alloc_req after reset", int'(alloc_req), 0);
        check(!mem_we && !rxq_push && !rx_irq_set, "R11", "write/push/irq after reset",
              int'(mem_we) + int'(rxq_push) + int'(rx_irq_set), 0);

        run_frame(100, 1'b0, 2, 1);    // long even, CRC kept
        run_frame(101, 1'b0, 1, 2);    // long odd: odd byte in trailer with 0x60
        run_frame(40, 1'b1, 0, 3);     // short even, padded, no CRC
        run_frame(41, 1'b0, 3, 4);     // short odd: odd byte before padding
        run_frame(1520, 1'b1, 1, 6);   // too-long flag
        run_frame(2039, 1'b0, 2, 7);   // count exactly 2048

        run_drop(60, 1'b0, 1'b0, 1'b0, 1'b1, "R1");   // receive disabled
        run_drop(70, 1'b1, 1'b1, 1'b1, 1'b1, "R1");   // soft reset held
        run_drop(2040, 1'b0, 1'b1, 1'b0, 1'b1, "R2"); // count 2050
        run_drop(80, 1'b0, 1'b1, 1'b0, 1'b0, "R3");   // no page free

        run_frame(64, 1'b0, 0, 9);     // recovers after drops

        check(ready_viol == 0, "R10", "s_ready during non-payload phases", ready_viol, 0);
        check(req_viol == 0, "R10", "alloc_req dropped before grant", req_viol, 0);
        check(exp_q.size() == 0, "R9", "pending expected pushes", exp_q.size(), 0);
        finish_run();
    end

endmodule